// File: doc/BRIEF.md
# I2C Serial Bit-Clock Divider

This block turns a stream of single-cycle enable ticks from a prescaler into the square serial bit clock used by an I2C controller. It holds an 8-bit divide-ratio register that software can write and read, and it takes a filter-enable flag from the controller's mode settings. Each half of the bit clock lasts a number of ticks given by the programmed ratio plus a fixed offset of three, plus two more when the input filter is enabled. The output therefore runs at the tick rate divided by twice that sum, with equal high and low times.

The ratio has a floor that depends on the filter flag: 3 with the filter off and 6 with it on. A smaller programmed value is replaced by the floor inside the divider, while a register read still returns exactly what was written. A new ratio or filter setting takes hold only when the current half-period ends, so the output never shows a shortened high or low phase. A run input gates the divider; while it is low the bit clock rests high, which is the bus idle level. Alongside the level, the block gives one-cycle rise and fall pulses that line up with each level change, for use by the bit engine.

Everything is registered in one clock domain with a synchronous active-low reset.

Top module: `i2c_bitclk_div`

## Requirements
- R1: After reset the ratio register reads 0xFF, `bclk` is high and neither `bclk_rise` nor `bclk_fall` is asserted.
- R2: A write with `reg_wr` high stores `reg_wdata`; `reg_rdata` returns exactly that value from the next cycle on, including values below the floor.
- R3: With `run_en` high, every high phase and every low phase of `bclk` lasts DIV + 3 + 2·FLT ticks, where DIV is the stored ratio and FLT is `flt_en` (1 = filter on).
- R4: A stored DIV below the floor (3 when `flt_en` = 0, 6 when `flt_en` = 1) makes each phase last floor + 3 + 2·FLT ticks.
- R5: Only cycles with `tick_en` high advance the divider; cycles with `tick_en` low change neither `bclk` nor the phase count.
- R6: A change of the ratio or of `flt_en` during a phase leaves that phase at its old length; the next phase uses the new length.
- R7: While `run_en` is low, `bclk` is high, no edge pulse is given and the phase count is cleared; after `run_en` returns high the first edge is a fall after one full phase length.
- R8: `bclk_rise` (`bclk_fall`) is high for exactly the one cycle in which `bclk` has just changed from low to high (high to low); the two are never high together, and with `run_en` high no level change occurs without its pulse.
- R9: Dropping `run_en` during a low phase returns `bclk` high on the next cycle with no `bclk_rise` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Prescaler tick; the divider counts only in cycles where this is high |
| run_en | input | 1 | Divider enable; low holds the bit clock idle high |
| flt_en | input | 1 | Input-filter enable from the mode settings; adds two ticks per phase and raises the floor |
| reg_wr | input | 1 | Write strobe for the ratio register |
| reg_wdata | input | 8 | Ratio value to write |
| reg_rdata | output | 8 | Current contents of the ratio register |
| bclk | output | 1 | Serial bit clock, registered |
| bclk_rise | output | 1 | One-cycle pulse with each low-to-high change of `bclk` |
| bclk_fall | output | 1 | One-cycle pulse with each high-to-low change of `bclk` |

## Verification
The hardest cases to reach are a ratio or filter change that lands in the middle of a running phase, and a stop that arrives while the clock is low. The bench reaches them by synchronising to an observed edge pulse, waiting a few cycles so the change falls well inside the phase, and then writing the register, flipping the filter flag or dropping the run input; it then measures the length of the phase in progress and of the one after it. A sweep over ratios both below and above the floor, with both filter settings and several tick spacings, measures every phase in ticks between pulses and compares it with the arithmetic value.

// File: rtl/i2c_bclk_pkg.sv
// Shared definitions for the I2C bit-clock divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2c_bclk_pkg;

    // Level of the bit clock; the idle level is high.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } bclk_phase_e;

    localparam bclk_phase_e BCLK_IDLE = PH_HIGH;

endpackage

// File: rtl/i2c_bclk_ratio_reg.sv
// Divide-ratio storage register.
// Holds the value software wrote; resets to all ones.
// Assumes: single write strobe, no byte enables.
module i2c_bclk_ratio_reg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_q
);

    // Store the written ratio; all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '1;
        end else if (wr_en) begin
            div_q <= wr_data;
        end
    end

endmodule

// File: rtl/i2c_bclk_phase_calc.sv
// Half-period length calculator.
// Applies the filter-dependent floor to the ratio and adds the fixed
// offset plus the filter extra. Purely combinational.
// Assumes: LEN_W wide enough for (2**DIV_W - 1) + OFFSET + FLT_EXTRA.
module i2c_bclk_phase_calc #(
    parameter int DIV_W         = 8,
    parameter int LEN_W         = 9,
    parameter int OFFSET        = 3,
    parameter int FLT_EXTRA     = 2,
    parameter int MIN_DIV_NOFLT = 3,
    parameter int MIN_DIV_FLT   = 6
) (
    input  logic [DIV_W-1:0] div,
    input  logic             flt,
    output logic [LEN_W-1:0] phase_len
);

    localparam logic [DIV_W-1:0] FLOOR_NF = DIV_W'(MIN_DIV_NOFLT);
    localparam logic [DIV_W-1:0] FLOOR_F  = DIV_W'(MIN_DIV_FLT);
    localparam logic [LEN_W-1:0] OFS_L    = LEN_W'(OFFSET);
    localparam logic [LEN_W-1:0] EXTRA_L  = LEN_W'(FLT_EXTRA);

    logic [DIV_W-1:0] floor_sel;
    logic [DIV_W-1:0] div_eff;

    // Clamp the ratio to the floor for the current filter setting.
    always_comb begin
        floor_sel = flt ? FLOOR_F : FLOOR_NF;
        div_eff   = (div < floor_sel) ? floor_sel : div;
    end

    // Phase length in ticks: clamped ratio + offset + filter extra.
    always_comb begin
        phase_len = LEN_W'(div_eff) + OFS_L + (flt ? EXTRA_L : LEN_W'(0));
    end

endmodule

// File: rtl/i2c_bclk_phase_gen.sv
// Phase counter and bit-clock toggle.
// Counts ticks within a phase, toggles the bit clock at the end of each
// phase and emits rise/fall pulses in the cycle the level changes.
// The phase length is sampled only at phase boundaries or while stopped.
// Assumes: len_next >= 2.
module i2c_bclk_phase_gen
    import i2c_bclk_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [LEN_W-1:0] len_next,
    output logic             bclk,
    output logic             rise,
    output logic             fall
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    bclk_phase_e      lvl_q;
    logic             rise_q;
    logic             fall_q;
    logic             last_tick;

    // Last tick of the current phase.
    always_comb begin
        last_tick = (cnt_q == (len_q - LEN_W'(1)));
    end

    // Advance the phase count, toggle the level, pulse the edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            len_q  <= len_next;
            lvl_q  <= BCLK_IDLE;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else if (tick && last_tick) begin
            cnt_q  <= '0;
            len_q  <= len_next;
            lvl_q  <= (lvl_q == PH_HIGH) ? PH_LOW : PH_HIGH;
            rise_q <= (lvl_q == PH_LOW);
            fall_q <= (lvl_q == PH_HIGH);
        end else begin
            if (tick) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        bclk = (lvl_q == PH_HIGH);
        rise = rise_q;
        fall = fall_q;
    end

endmodule

// File: rtl/i2c_bitclk_div.sv
// I2C serial bit-clock divider, top level.
// Ratio register, floor/offset calculation and phase generator.
// Assumes: tick_en comes from a prescaler in the same clock domain.
module i2c_bitclk_div #(
    parameter int DIV_W         = 8,
    parameter int OFFSET        = 3,
    parameter int FLT_EXTRA     = 2,
    parameter int MIN_DIV_NOFLT = 3,
    parameter int MIN_DIV_FLT   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    input  logic             flt_en,
    input  logic             reg_wr,
    input  logic [DIV_W-1:0] reg_wdata,
    output logic [DIV_W-1:0] reg_rdata,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall
);

    localparam int MAX_LEN = (2 ** DIV_W) - 1 + OFFSET + FLT_EXTRA;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_next;

    i2c_bclk_ratio_reg #(
        .DIV_W(DIV_W)
    ) ratio_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_data(reg_wdata),
        .div_q  (div_q)
    );

    i2c_bclk_phase_calc #(
        .DIV_W        (DIV_W),
        .LEN_W        (LEN_W),
        .OFFSET       (OFFSET),
        .FLT_EXTRA    (FLT_EXTRA),
        .MIN_DIV_NOFLT(MIN_DIV_NOFLT),
        .MIN_DIV_FLT  (MIN_DIV_FLT)
    ) calc_i (
        .div      (div_q),
        .flt      (flt_en),
        .phase_len(len_next)
    );

    i2c_bclk_phase_gen #(
        .LEN_W(LEN_W)
    ) gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .run     (run_en),
        .len_next(len_next),
        .bclk    (bclk),
        .rise    (bclk_rise),
        .fall    (bclk_fall)
    );

    // Register read-back.
    always_comb begin
        reg_rdata = div_q;
    end

endmodule

// File: rtl/i2c_bitclk_div_chk.sv
// Property checker for the I2C bit-clock divider, bound to the top.
// Assumes: rst_n is held low from time zero for at least one edge.
module i2c_bitclk_div_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             run_en,
    input logic             reg_wr,
    input logic [DIV_W-1:0] reg_wdata,
    input logic [DIV_W-1:0] reg_rdata,
    input logic             bclk,
    input logic             bclk_rise,
    input logic             bclk_fall
);

    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr)) |-> (reg_rdata == $past(reg_wdata)));

    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && !$past(tick_en)) |-> $stable(bclk));

    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> (bclk && !bclk_rise && !bclk_fall));

    p_rise_marks_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |-> (bclk && !$past(bclk)));

    p_fall_marks_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |-> (!bclk && $past(bclk)));

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bclk_rise, bclk_fall}));

    p_change_has_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en) && (bclk != $past(bclk))) |-> (bclk_rise || bclk_fall));

    p_single_cycle_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise || bclk_fall) |=> !(bclk_rise || bclk_fall));

endmodule

bind i2c_bitclk_div i2c_bitclk_div_chk #(.DIV_W(DIV_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run_en   (run_en),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .bclk     (bclk),
    .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall)
);

// File: tb/i2c_bitclk_div_tb_top.sv
// Self-checking bench: measures each bit-clock phase in ticks between
// edge pulses and compares with the arithmetic phase length.
module i2c_bitclk_div_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       run_en = 1'b0;
    logic       flt_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bclk;
    logic       bclk_rise;
    logic       bclk_fall;

    int n_checks = 0;
    int n_errors = 0;
    int tick_period = 1;
    int tick_ph = 0;
    int ticks = 0;
    int edge_cnt = 0;
    int edge_ticks = 0;
    bit edge_rise = 1'b0;
    logic prev_bclk = 1'b1;

    i2c_bitclk_div dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run_en   (run_en),
        .flt_en   (flt_en),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .bclk     (bclk),
        .bclk_rise(bclk_rise),
        .bclk_fall(bclk_fall)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int dv, input int f);
        int fl;
        fl = (f != 0) ? 6 : 3;
        if (dv < fl) dv = fl;
        return dv + 3 + 2 * f;
    endfunction

    // Monitor: count ticks seen at each edge, record edges, check pulses (R8).
    always @(negedge clk) begin
        if (rst_n && run_en) begin
            if (tick_en) ticks++;
        end else begin
            ticks = 0;
        end
        if (rst_n) begin
            if (bclk_rise && bclk_fall) chk(1'b0, "R8 both pulses", 1, 0);
            if (bclk_rise || bclk_fall) begin
                if (bclk_rise) chk(bclk && !prev_bclk, "R8 rise level", int'(bclk), 1);
                if (bclk_fall) chk(!bclk && prev_bclk, "R8 fall level", int'(bclk), 0);
                edge_ticks = ticks;
                ticks = 0;
                edge_rise = bclk_rise;
                edge_cnt++;
            end else if (run_en && (bclk !== prev_bclk)) begin
                chk(1'b0, "R8 change without pulse", int'(bclk), int'(prev_bclk));
            end
        end
        prev_bclk = bclk;
        tick_en = (tick_ph == 0);
        tick_ph = (tick_ph + 1 >= tick_period) ? 0 : tick_ph + 1;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_run(input bit b);
        @(negedge clk);
        #1 run_en = b;
    endtask

    task automatic write_div(input int d);
        @(negedge clk);
        #1;
        reg_wr = 1'b1;
        reg_wdata = 8'(d);
        @(negedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic expect_edge(input bit rise, input int len, input string tag);
        int start;
        int waited;
        start = edge_cnt;
        waited = 0;
        while (edge_cnt == start && waited < 4000) begin
            @(negedge clk);
            #2;
            waited++;
        end
        if (edge_cnt == start) begin
            chk(1'b0, {tag, " timeout"}, -1, len);
        end else begin
            chk(edge_rise == rise, {tag, " edge direction"}, int'(edge_rise), int'(rise));
            chk(edge_ticks == len, {tag, " phase ticks"}, edge_ticks, len);
        end
    endtask

    // Configure, start and measure two full periods.
    task automatic measure(input int dv, input int f, input string tag);
        int len;
        len = exp_len(dv, f);
        set_run(1'b0);
        write_div(dv);
        chk(reg_rdata == 8'(dv), "R2 readback", int'(reg_rdata), dv);
        flt_en = f[0];
        cycles(2);
        set_run(1'b1);
        expect_edge(1'b0, len, tag);
        expect_edge(1'b1, len, tag);
        expect_edge(1'b0, len, tag);
        expect_edge(1'b1, len, tag);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int divs[11] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 17, 255};
        int saved;
        bit idle_ok;

        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        chk(reg_rdata == 8'hFF, "R1 reset ratio", int'(reg_rdata), 255);
        chk(bclk == 1'b1, "R1 reset bclk", int'(bclk), 1);
        chk(!bclk_rise && !bclk_fall, "R1 reset pulses", int'({bclk_rise, bclk_fall}), 0);

        // R3/R4 sweep, tick every cycle
        for (int f = 0; f < 2; f++) begin
            foreach (divs[i]) begin
                measure(divs[i], f, (divs[i] < ((f != 0) ? 6 : 3)) ? "R4 clamp" : "R3 phase");
            end
        end

        // R5 sparse ticks
        for (int p = 3; p <= 5; p += 2) begin
            tick_period = p;
            measure(4, 1, "R5 sparse ticks clamp");
            measure(10, 0, "R5 sparse ticks");
        end
        tick_period = 1;

        // R6 ratio change mid-phase
        measure(10, 0, "R6 setup");
        cycles(4);
        write_div(20);
        expect_edge(1'b0, 13, "R6 old ratio kept");
        expect_edge(1'b1, 23, "R6 new ratio");
        cycles(3);
        flt_en = 1'b1;
        expect_edge(1'b0, 23, "R6 old filter kept");
        expect_edge(1'b1, 25, "R6 new filter");

        // R9 stop during low phase
        measure(3, 0, "R9 setup");
        expect_edge(1'b0, 6, "R9 setup");
        saved = edge_cnt;
        set_run(1'b0);
        @(negedge clk);
        #2;
        chk(bclk == 1'b1, "R9 bclk high after stop", int'(bclk), 1);
        chk(edge_cnt == saved, "R9 no rise pulse", edge_cnt - saved, 0);

        // R7 idle hold and restart
        idle_ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            #2;
            if (bclk != 1'b1 || edge_cnt != saved) idle_ok = 1'b0;
        end
        chk(idle_ok, "R7 idle high no pulses", int'(idle_ok), 1);
        set_run(1'b1);
        expect_edge(1'b0, 6, "R7 restart full phase");
        expect_edge(1'b1, 6, "R7 restart");

        set_run(1'b0);
        cycles(3);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule